// File: doc/BRIEF.md
# GPIO Interrupt Enable and Status Controller

This block turns per-channel input-change events, reported by a GPIO core, into one active-high interrupt request. Each channel has a sticky status bit that records an event, an enable bit that lets the status reach the output, and one global enable that gates the whole output. Software reads and writes the three registers over a simple register bus with a single-cycle write strobe and a combinational read port.

A status bit is cleared by writing 1 to it, and the same write sets it when it is clear. Bits written 0 keep their value, so the service routine never needs a read-modify-write. It can clear only the bits it has handled, and events that arrive in the meantime are kept. The block supports one or two channels, and interrupt support can be left out entirely by parameter.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Byte addresses decode exactly: global enable at 0x11C, status at 0x120, channel enable at 0x128. Any other address reads as zero, and writes to it change no register.
- R2: The global enable is bit 31 of its word and resets to 0. Bits 30..0 of that word read as zero.
- R3: In the status and channel enable words, bit 0 belongs to channel 1 and bit 1 to channel 2. Both bits reset to 0, and bits 31..2 read as zero.
- R4: In a status write, each data bit of 1 inverts the matching status bit and each data bit of 0 leaves it unchanged.
- R5: When `chan_evt[c]` is high at a rising clock edge, status bit c is set at that edge, whatever the value of the channel's enable bit.
- R6: When an event and a status write with data bit 1 reach the same status bit at the same edge, the bit ends up set.
- R7: `irq` is a register. After each edge it equals the global enable ANDed with the OR over the channels of (status AND enable), taken from the register values held before that edge.
- R8: With `DUAL` = 0, bit 1 of the status and enable words always reads 0 and cannot be set by a write or by an event.
- R9: With `IRQ_ON` = 0, all three registers read as zero and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and for sampling events |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte address, used for both reads and writes |
| wdata | input | DATA_W | Write data |
| chan_evt | input | 2 | Change event per channel, sampled at the clock edge |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench covers every combination of global enable, channel enables and events, and every start status × write data × event pattern in a toggle write. It runs three configurations side by side: dual channel, single channel, and interrupt support left out. A design that let a software toggle win over a simultaneous event would lose that event in the collision sweep. A design that gated capture with the enable bit would show a zero status after a masked event. The checks also catch an `irq` that is combinational or drives a cycle late, because the bench samples one cycle after each change. They also catch a single-channel build whose bit 1 can be set, or a build without interrupt support that still answers reads.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter bit DUAL = 1'b1,
  parameter bit IRQ_ON = 1'b1,
  parameter logic [ADDR_W-1:0] GIE_OFS = 9'h11C,
  parameter logic [ADDR_W-1:0] STS_OFS = 9'h120,
  parameter logic [ADDR_W-1:0] IER_OFS = 9'h128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        chan_evt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int NCH = DUAL ? 2 : 1;

  logic       gie_q;
  logic [1:0] ier_q, sts_q;

  wire wr_gie = wr_en && (addr == GIE_OFS);
  wire wr_sts = wr_en && (addr == STS_OFS);
  wire wr_ier = wr_en && (addr == IER_OFS);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    if (IRQ_ON && c < NCH) begin : g_on
      always_ff @(posedge clk) begin
        if (rst) begin
          ier_q[c] <= 1'b0;
          sts_q[c] <= 1'b0;
        end else begin
          if (wr_ier) ier_q[c] <= wdata[c];
          sts_q[c] <= (sts_q[c] ^ (wr_sts & wdata[c])) | chan_evt[c];
        end
      end

      // R5
      evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
        chan_evt[c] |=> sts_q[c]);
      // R4
      toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && wdata[c] && !chan_evt[c]) |=> (sts_q[c] != $past(sts_q[c])));
      // R4
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_sts && wdata[c]) && !chan_evt[c]) |=> $stable(sts_q[c]));
    end else begin : g_off
      assign ier_q[c] = 1'b0;
      assign sts_q[c] = 1'b0;
      // R8
      absent_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == STS_OFS || addr == IER_OFS) |-> !rdata[c]);
    end
  end

  if (IRQ_ON) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) begin
        gie_q <= 1'b0;
        irq   <= 1'b0;
      end else begin
        if (wr_gie) gie_q <= wdata[DATA_W-1];
        irq <= gie_q & |(sts_q & ier_q);
      end
    end

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
      irq |-> $past(gie_q));
    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> $past(|(sts_q & ier_q)));
  end else begin : g_noirq
    assign gie_q = 1'b0;
    assign irq   = 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (addr == GIE_OFS) rdata[DATA_W-1] = gie_q;
    else if (addr == STS_OFS) rdata[1:0] = sts_q;
    else if (addr == IER_OFS) rdata[1:0] = ier_q;
  end
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam logic [8:0] A_GIE = 9'h11C, A_STS = 9'h120, A_IER = 9'h128;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0] chan_evt = '0;
  logic [31:0] rd_d, rd_s, rd_o;
  logic irq_d, irq_s, irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic gie_m = 1'b0, irq_m = 1'b0;
  logic [1:0] ier_m = '0, sts_m = '0;

  always #5 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (.clk, .rst, .wr_en, .addr, .wdata, .chan_evt,
    .rdata(rd_d), .irq(irq_d));
  gpio_irq_ctrl #(.DUAL(1'b0)) i_gpio_irq_ctrl_single (.clk, .rst, .wr_en, .addr,
    .wdata, .chan_evt, .rdata(rd_s), .irq(irq_s));
  gpio_irq_ctrl #(.IRQ_ON(1'b0)) i_gpio_irq_ctrl_off (.clk, .rst, .wr_en, .addr,
    .wdata, .chan_evt, .rdata(rd_o), .irq(irq_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [8:0] a, bit single);
    logic [1:0] m = single ? 2'b01 : 2'b11;
    if (a == A_GIE) return {gie_m, 31'b0};
    if (a == A_STS) return {30'b0, sts_m & m};
    if (a == A_IER) return {30'b0, ier_m & m};
    return '0;
  endfunction

  task automatic read_all(string req, logic [8:0] a);
    addr = a;
    #1;
    chk(req, rd_d, exp_rd(a, 1'b0));
    chk({req, "/R8"}, rd_s, exp_rd(a, 1'b1));
    chk({req, "/R9"}, rd_o, 32'h0);
  endtask

  task automatic cyc(bit we, logic [8:0] a, logic [31:0] d, logic [1:0] ev);
    wr_en = we; addr = a; wdata = d; chan_evt = ev;
    @(posedge clk);
    irq_m = gie_m & |(sts_m & ier_m);
    if (we && a == A_GIE) gie_m = d[31];
    if (we && a == A_IER) ier_m = d[1:0];
    if (we && a == A_STS) sts_m = sts_m ^ d[1:0];
    sts_m = sts_m | ev;
    @(negedge clk);
    wr_en = 1'b0; chan_evt = '0;
    chk("R7 dual irq", {31'b0, irq_d}, {31'b0, irq_m});
  endtask

  task automatic cyc_single_irq_check(logic single_exp);
    chk("R8 single irq", {31'b0, irq_s}, {31'b0, single_exp});
    chk("R9 irq off", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    read_all("R2 reset gie", A_GIE);
    read_all("R3 reset sts", A_STS);
    read_all("R3 reset ier", A_IER);
    chk("R7 reset irq", {31'b0, irq_d}, 32'h0);

    // R1: writes to other addresses have no effect
    cyc(1'b1, 9'h124, 32'hFFFF_FFFF, 2'b00);
    cyc(1'b1, 9'h11D, 32'hFFFF_FFFF, 2'b00);
    read_all("R1 stray gie", A_GIE);
    read_all("R1 stray sts", A_STS);
    read_all("R1 stray ier", A_IER);
    read_all("R1 unmapped", 9'h000);

    // R2/R3: unused bits read zero
    cyc(1'b1, A_GIE, 32'hFFFF_FFFF, 2'b00);
    cyc(1'b1, A_IER, 32'hFFFF_FFFF, 2'b00);
    read_all("R2 gie only msb", A_GIE);
    read_all("R3 ier two bits", A_IER);

    // Sweep: gie x ier x events; R5 capture regardless of enable, R7 output
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 4; e++)
        for (int v = 0; v < 4; v++) begin
          cyc(1'b1, A_GIE, {g[0], 31'b0}, 2'b00);
          cyc(1'b1, A_IER, {30'b0, e[1:0]}, 2'b00);
          cyc(1'b1, A_STS, {30'b0, sts_m}, 2'b00);
          read_all("R4 cleared", A_STS);
          cyc(1'b0, A_STS, 32'h0, v[1:0]);
          read_all("R5 capture", A_STS);
          cyc(1'b0, A_STS, 32'h0, 2'b00);
          cyc_single_irq_check(g[0] & v[0] & e[0]);
        end

    // Sweep: start status x write data x simultaneous event (R4, R6)
    cyc(1'b1, A_GIE, 32'h8000_0000, 2'b00);
    cyc(1'b1, A_IER, 32'h3, 2'b00);
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        for (int v = 0; v < 4; v++) begin
          cyc(1'b1, A_STS, {30'b0, sts_m ^ s[1:0]}, 2'b00);
          read_all("R4 preset", A_STS);
          cyc(1'b1, A_STS, {30'b0, w[1:0]}, v[1:0]);
          read_all("R6 toggle vs event", A_STS);
          chk("R6 value", {30'b0, sts_m}, {30'b0, (s[1:0] ^ w[1:0]) | v[1:0]});
        end
    cyc(1'b0, A_STS, 32'h0, 2'b00);
    cyc(1'b0, A_STS, 32'h0, 2'b00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule